// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a single-port data cache for word reads and writes. The main store is direct-mapped: each set holds one line. Beside it sits a small fully associative buffer that keeps lines pushed out of the main store. When a request misses in the main store but its line is in the buffer, the two lines trade places. The request then completes without any memory traffic. Two blocks that keep colliding on one set therefore cost only their first two fetches.

The processor side takes one request at a time through a valid/ready pair. Each request produces one response, carrying the read word and a status flag that says how it was served. The memory side works on whole lines. It issues one request at a time and holds it until a single-beat valid returns. Writes use write-allocate and write-back. A dirty line leaves the chip only when it drops out of the buffer, and it is written out before the refill read is issued.

Top module: `victim_cache`

## Requirements
- R1: After reset `req_ready_o` is 1, and `resp_valid_o`, all three status flags and `mem_req_o` are 0.
- R2: A word address splits into a line offset in its low `log2(LINE_WORDS)` bits, a set index in the next `log2(SETS)` bits and a tag in the rest. A request whose line is in the main store responds in the first cycle after acceptance, with `stat_main_hit_o` set and no memory request.
- R3: A request found in neither store issues a line read with `mem_line_addr_o` equal to the word address shifted right by the offset width. When that line returns, the request responds with `stat_miss_o` set.
- R4: On a refill, a valid line that was in the main store moves into the victim buffer and is not dropped. A later access to it is a victim hit.
- R5: A request that misses in the main store and hits in the buffer responds in the second cycle after acceptance, with `stat_victim_hit_o` set and no memory request. Its line moves into the main store and the displaced main line takes its buffer entry.
- R6: When two blocks alternate on one set, only the first access to each reaches memory. Every later access is a victim hit.
- R7: A line entering the buffer takes the lowest-numbered empty entry. If there is none, it takes the least recently filled entry.
- R8: If the buffer entry to be replaced holds a dirty line, that whole line is written to memory before the refill read is issued. Clean lines are dropped with no memory write.
- R9: Writes use write-allocate. A written word is returned by later reads whether the line sits in the main store, in the buffer, or has been written back and fetched again.
- R10: Each response raises exactly one of the three status flags. All flags are 0 when no response is given.
- R11: `mem_req_o`, `mem_we_o`, `mem_line_addr_o` and `mem_wline_o` stay stable from the cycle the request is raised until `mem_valid_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request present |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Block idle and accepting a request |
| resp_valid_o | output | 1 | Response for the accepted request |
| resp_rdata_o | output | DATA_W | Read word (meaningful for reads) |
| stat_main_hit_o | output | 1 | Served from the main store |
| stat_victim_hit_o | output | 1 | Served from the victim buffer by a swap |
| stat_miss_o | output | 1 | Served after a memory fetch |
| mem_req_o | output | 1 | Memory request pending |
| mem_we_o | output | 1 | 1 = line write-back, 0 = line read |
| mem_line_addr_o | output | ADDR_W-log2(LINE_WORDS) | Line address |
| mem_wline_o | output | DATA_W*LINE_WORDS | Line being written back |
| mem_valid_i | input | 1 | Memory done; read line valid |
| mem_rline_i | input | DATA_W*LINE_WORDS | Line returned by a read |

## Verification
The assertions assume that memory answers each request with exactly one `mem_valid_i` pulse and never raises it when no request is pending. They also assume that processor inputs are sampled only when `req_ready_o` is high. The memory model in the bench raises valid for a single cycle a fixed delay after it sees a request, and only while `mem_req_o` is high. The driver raises `req_valid_i` only after it sees `req_ready_o` and waits for each response before sending the next request, so no request overlaps another.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_SWAP,
    ST_WBACK,
    ST_FILL
  } vc_state_e;
endpackage

// File: rtl/vc_main_array.sv
module vc_main_array #(
  parameter int SETS   = 16,
  parameter int TAG_W  = 10,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic              rd_dirty_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [LINE_W-1:0] rd_line_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic              wr_dirty_i
);
  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= 1'b1;
      dirty_q[wr_idx_i] <= wr_dirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      line_q[wr_idx_i] <= wr_line_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_line_o  = line_q[rd_idx_i];
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int WAYS    = 4,
  parameter int LADDR_W = 14,
  parameter int LINE_W  = 128,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LADDR_W-1:0] look_addr_i,
  output logic               hit_o,
  output logic [WAY_W-1:0]   hit_way_o,
  output logic               hit_dirty_o,
  output logic [LINE_W-1:0]  hit_line_o,
  output logic [WAY_W-1:0]   alloc_way_o,
  output logic               alloc_valid_o,
  output logic               alloc_dirty_o,
  output logic [LADDR_W-1:0] alloc_addr_o,
  output logic [LINE_W-1:0]  alloc_line_o,
  input  logic               wr_en_i,
  input  logic [WAY_W-1:0]   wr_way_i,
  input  logic               wr_valid_i,
  input  logic               wr_dirty_i,
  input  logic [LADDR_W-1:0] wr_addr_i,
  input  logic [LINE_W-1:0]  wr_line_i
);
  logic [WAYS-1:0]    valid_q;
  logic [WAYS-1:0]    dirty_q;
  logic [LADDR_W-1:0] addr_q [WAYS];
  logic [LINE_W-1:0]  line_q [WAYS];
  logic [WAY_W-1:0]   age_q  [WAYS];

  // associative search, lowest way wins
  always_comb begin
    hit_o     = 1'b0;
    hit_way_o = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!hit_o && valid_q[i] && addr_q[i] == look_addr_i) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(i);
      end
    end
  end

  // empty entry first, else oldest
  always_comb begin
    logic found;
    found       = 1'b0;
    alloc_way_o = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!found && !valid_q[i]) begin
        found       = 1'b1;
        alloc_way_o = WAY_W'(i);
      end
    end
    if (!found) begin
      for (int i = 0; i < WAYS; i++) begin
        if (age_q[i] == WAY_W'(WAYS - 1)) alloc_way_o = WAY_W'(i);
      end
    end
  end

  assign hit_dirty_o   = dirty_q[hit_way_o];
  assign hit_line_o    = line_q[hit_way_o];
  assign alloc_valid_o = valid_q[alloc_way_o];
  assign alloc_dirty_o = dirty_q[alloc_way_o];
  assign alloc_addr_o  = addr_q[alloc_way_o];
  assign alloc_line_o  = line_q[alloc_way_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int j = 0; j < WAYS; j++) age_q[j] <= WAY_W'(j);
    end else if (wr_en_i) begin
      valid_q[wr_way_i] <= wr_valid_i;
      dirty_q[wr_way_i] <= wr_dirty_i;
      for (int j = 0; j < WAYS; j++) begin
        if (WAY_W'(j) == wr_way_i)          age_q[j] <= '0;
        else if (age_q[j] < age_q[wr_way_i]) age_q[j] <= age_q[j] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      addr_q[wr_way_i] <= wr_addr_i;
      line_q[wr_way_i] <= wr_line_i;
    end
  end
endmodule

// File: rtl/victim_cache.sv
module victim_cache
  import vc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 16,
  parameter int VB_WAYS    = 4,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(SETS),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int LADDR_W   = ADDR_W - OFF_W,
  localparam int LINE_W    = DATA_W * LINE_WORDS,
  localparam int WAY_W     = (VB_WAYS > 1) ? $clog2(VB_WAYS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_we_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               req_ready_o,
  output logic               resp_valid_o,
  output logic [DATA_W-1:0]  resp_rdata_o,
  output logic               stat_main_hit_o,
  output logic               stat_victim_hit_o,
  output logic               stat_miss_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [LADDR_W-1:0] mem_line_addr_o,
  output logic [LINE_W-1:0]  mem_wline_o,
  input  logic               mem_valid_i,
  input  logic [LINE_W-1:0]  mem_rline_i
);
  vc_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              miss_q, miss_d;

  logic [OFF_W-1:0]   off;
  logic [IDX_W-1:0]   idx;
  logic [TAG_W-1:0]   tag;
  logic [LADDR_W-1:0] laddr;
  assign off   = addr_q[OFF_W-1:0];
  assign idx   = addr_q[OFF_W+:IDX_W];
  assign tag   = addr_q[ADDR_W-1-:TAG_W];
  assign laddr = addr_q[ADDR_W-1:OFF_W];

  logic              m_valid, m_dirty;
  logic [TAG_W-1:0]  m_tag;
  logic [LINE_W-1:0] m_line;
  logic              m_wr_en, m_wr_dirty;
  logic [LINE_W-1:0] m_wr_line;

  logic               v_hit, v_hit_dirty, v_alloc_valid, v_alloc_dirty;
  logic [WAY_W-1:0]   v_hit_way, v_alloc_way;
  logic [LINE_W-1:0]  v_hit_line, v_alloc_line;
  logic [LADDR_W-1:0] v_alloc_addr;
  logic               v_wr_en, v_wr_valid;
  logic [WAY_W-1:0]   v_wr_way;

  vc_main_array #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_main (
    .clk_i, .rst_ni,
    .rd_idx_i   (idx),
    .rd_valid_o (m_valid),
    .rd_dirty_o (m_dirty),
    .rd_tag_o   (m_tag),
    .rd_line_o  (m_line),
    .wr_en_i    (m_wr_en),
    .wr_idx_i   (idx),
    .wr_tag_i   (tag),
    .wr_line_i  (m_wr_line),
    .wr_dirty_i (m_wr_dirty)
  );

  vc_victim_buf #(.WAYS(VB_WAYS), .LADDR_W(LADDR_W), .LINE_W(LINE_W)) u_vbuf (
    .clk_i, .rst_ni,
    .look_addr_i   (laddr),
    .hit_o         (v_hit),
    .hit_way_o     (v_hit_way),
    .hit_dirty_o   (v_hit_dirty),
    .hit_line_o    (v_hit_line),
    .alloc_way_o   (v_alloc_way),
    .alloc_valid_o (v_alloc_valid),
    .alloc_dirty_o (v_alloc_dirty),
    .alloc_addr_o  (v_alloc_addr),
    .alloc_line_o  (v_alloc_line),
    .wr_en_i       (v_wr_en),
    .wr_way_i      (v_wr_way),
    .wr_valid_i    (v_wr_valid),
    .wr_dirty_i    (m_dirty),
    .wr_addr_i     ({m_tag, idx}),
    .wr_line_i     (m_line)
  );

  logic main_hit;
  logic [LINE_W-1:0] src_line, merged_line;
  assign main_hit = m_valid && (m_tag == tag);
  assign src_line = (state_q == ST_SWAP) ? v_hit_line : m_line;

  always_comb begin
    merged_line = src_line;
    if (we_q) merged_line[off*DATA_W +: DATA_W] = wdata_q;
  end

  always_comb begin
    state_d           = state_q;
    miss_d            = miss_q;
    req_ready_o       = 1'b0;
    resp_valid_o      = 1'b0;
    stat_main_hit_o   = 1'b0;
    stat_victim_hit_o = 1'b0;
    stat_miss_o       = 1'b0;
    mem_req_o         = 1'b0;
    mem_we_o          = 1'b0;
    mem_line_addr_o   = laddr;
    mem_wline_o       = v_alloc_line;
    m_wr_en           = 1'b0;
    m_wr_line         = merged_line;
    m_wr_dirty        = 1'b1;
    v_wr_en           = 1'b0;
    v_wr_way          = v_alloc_way;
    v_wr_valid        = m_valid;
    unique case (state_q)
      ST_IDLE: begin
        req_ready_o = 1'b1;
        if (req_valid_i) state_d = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (main_hit) begin
          resp_valid_o    = 1'b1;
          stat_main_hit_o = !miss_q;
          stat_miss_o     = miss_q;
          m_wr_en         = we_q;
          miss_d          = 1'b0;
          state_d         = ST_IDLE;
        end else if (v_hit) begin
          state_d = ST_SWAP;
        end else if (m_valid && v_alloc_valid && v_alloc_dirty) begin
          state_d = ST_WBACK;
        end else begin
          state_d = ST_FILL;
        end
      end
      ST_SWAP: begin
        resp_valid_o      = 1'b1;
        stat_victim_hit_o = 1'b1;
        m_wr_en           = 1'b1;
        m_wr_dirty        = v_hit_dirty | we_q;
        v_wr_en           = 1'b1;
        v_wr_way          = v_hit_way;
        state_d           = ST_IDLE;
      end
      ST_WBACK: begin
        mem_req_o       = 1'b1;
        mem_we_o        = 1'b1;
        mem_line_addr_o = v_alloc_addr;
        if (mem_valid_i) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req_o = 1'b1;
        if (mem_valid_i) begin
          m_wr_en    = 1'b1;
          m_wr_line  = mem_rline_i;
          m_wr_dirty = 1'b0;
          v_wr_en    = m_valid;
          miss_d     = 1'b1;
          state_d    = ST_LOOKUP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign resp_rdata_o = src_line[off*DATA_W +: DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      miss_q  <= 1'b0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      miss_q  <= miss_d;
      if (req_ready_o && req_valid_i) begin
        addr_q  <= req_addr_i;
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end
    end
  end
endmodule

// File: rtl/vc_chk.sv
module vc_chk #(
  parameter int LA_W = 14,
  parameter int LN_W = 128
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_ready_o,
  input logic            resp_valid_o,
  input logic            stat_main_hit_o,
  input logic            stat_victim_hit_o,
  input logic            stat_miss_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [LA_W-1:0] mem_line_addr_o,
  input logic [LN_W-1:0] mem_wline_o,
  input logic            mem_valid_i
);
  // R10
  one_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $countones({stat_main_hit_o, stat_victim_hit_o, stat_miss_o}) == 1);

  // R10
  quiet_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> !(stat_main_hit_o || stat_victim_hit_o || stat_miss_o));

  // R11
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=>
      (mem_req_o && $stable(mem_we_o) && $stable(mem_line_addr_o)
       && (!mem_we_o || $stable(mem_wline_o))));

  // R2
  main_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_main_hit_o |-> ($past(req_ready_o) && !mem_req_o));

  // R5
  victim_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_victim_hit_o |-> (!$past(req_ready_o) && !mem_req_o));

  // R1
  busy_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !req_ready_o);
endmodule

bind victim_cache vc_chk #(.LA_W(LADDR_W), .LN_W(LINE_W)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .req_ready_o       (req_ready_o),
  .resp_valid_o      (resp_valid_o),
  .stat_main_hit_o   (stat_main_hit_o),
  .stat_victim_hit_o (stat_victim_hit_o),
  .stat_miss_o       (stat_miss_o),
  .mem_req_o         (mem_req_o),
  .mem_we_o          (mem_we_o),
  .mem_line_addr_o   (mem_line_addr_o),
  .mem_wline_o       (mem_wline_o),
  .mem_valid_i       (mem_valid_i)
);

// File: tb/victim_cache_tb_top.sv
module victim_cache_tb_top;
  localparam int DW = 32, AW = 16, LW = 128, LAW = 14;
  localparam int K_MAIN = 0, K_VICT = 1, K_MISS = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, resp_valid, st_main, st_vict, st_miss;
  logic [DW-1:0] resp_rdata;
  logic          mem_req, mem_we, mem_valid = 1'b0;
  logic [LAW-1:0] mem_la;
  logic [LW-1:0] mem_wline, mem_rline = '0;

  victim_cache dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .resp_valid_o(resp_valid), .resp_rdata_o(resp_rdata),
    .stat_main_hit_o(st_main), .stat_victim_hit_o(st_vict), .stat_miss_o(st_miss),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_line_addr_o(mem_la),
    .mem_wline_o(mem_wline), .mem_valid_i(mem_valid), .mem_rline_i(mem_rline)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference word memory
  logic [DW-1:0] ref_mem [int];
  function automatic logic [DW-1:0] dflt(int a);
    return 32'hC0DE0000 | (a & 32'hFFFF);
  endfunction
  function automatic logic [DW-1:0] ref_word(int a);
    return ref_mem.exists(a) ? ref_mem[a] : dflt(a);
  endfunction

  // memory model
  logic [LW-1:0] mem_model [int];
  int n_rd = 0, n_wr = 0;
  int op_la[$];
  bit op_we[$];
  function automatic logic [LW-1:0] mem_line(int la);
    logic [LW-1:0] l;
    if (mem_model.exists(la)) return mem_model[la];
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = dflt(la * 4 + w);
    return l;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && rst_n) begin
        int la0; bit we0;
        la0 = int'(mem_la); we0 = mem_we;
        repeat (2) @(negedge clk);
        check(mem_req && int'(mem_la) == la0 && mem_we == we0, "R11",
              "memory request held", 32'(mem_la), 32'(la0));
        op_la.push_back(la0);
        op_we.push_back(we0);
        if (we0) begin
          n_wr++;
          mem_model[la0] = mem_wline;
        end else begin
          n_rd++;
          mem_rline = mem_line(la0);
        end
        mem_valid = 1'b1;
        @(negedge clk);
        mem_valid = 1'b0;
      end
    end
  end

  // scoreboard
  typedef struct {
    int          kind;
    bit          rd;
    logic [31:0] data;
    string       req;
  } exp_t;
  exp_t exp_q[$];
  int busy = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && resp_valid) begin
        exp_t e;
        int k;
        k = st_main ? K_MAIN : st_vict ? K_VICT : st_miss ? K_MISS : 3;
        if (exp_q.size() == 0) begin
          check(0, "R10", "unexpected response", 32'(k), 32'hFFFF);
        end else begin
          e = exp_q.pop_front();
          check($countones({st_main, st_vict, st_miss}) == 1, "R10",
                "one status flag", 32'({st_main, st_vict, st_miss}), 32'h0);
          check(k == e.kind, e.req, "status kind", 32'(k), 32'(e.kind));
          if (e.kind == K_MAIN)
            check(busy + 1 == 1, "R2", "main hit latency", 32'(busy + 1), 32'd1);
          if (e.kind == K_VICT)
            check(busy + 1 == 2, "R5", "victim hit latency", 32'(busy + 1), 32'd2);
          if (e.rd) check(resp_rdata == e.data, e.req, "read data", resp_rdata, e.data);
        end
        busy = 0;
      end else if (rst_n && !req_ready) begin
        busy++;
      end
    end
  end

  task automatic acc(bit we, int addr, logic [31:0] wd, int kind, string req);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (we) ref_mem[addr] = wd;
    e.kind = kind; e.rd = !we; e.data = ref_word(addr); e.req = req;
    exp_q.push_back(e);
    req_valid = 1'b1; req_we = we; req_addr = AW'(addr); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(req_ready && !resp_valid && !mem_req && !st_main && !st_vict && !st_miss,
          "R1", "reset outputs", {26'd0, req_ready, resp_valid, mem_req, st_main, st_vict, st_miss},
          32'h20);

    acc(0, 16'h0000, 0, K_MISS, "R3");
    check(n_rd == 1 && op_la[0] == 0, "R3", "fetch line address", 32'(op_la[0]), 32'h0);
    acc(0, 16'h0001, 0, K_MAIN, "R2");
    acc(0, 16'h0040, 0, K_MISS, "R3");
    acc(0, 16'h0000, 0, K_VICT, "R4");
    acc(0, 16'h0041, 0, K_VICT, "R5");
    acc(0, 16'h0002, 0, K_VICT, "R6");
    acc(0, 16'h0043, 0, K_VICT, "R6");
    acc(0, 16'h0003, 0, K_VICT, "R6");
    check(n_rd == 2, "R6", "ping-pong memory reads", 32'(n_rd), 32'd2);

    acc(1, 16'h0001, 32'hDEADBEEF, K_MAIN, "R9");
    acc(0, 16'h0001, 0, K_MAIN, "R9");

    acc(0, 16'h0080, 0, K_MISS, "R7");
    acc(0, 16'h00C0, 0, K_MISS, "R7");
    acc(0, 16'h0100, 0, K_MISS, "R7");
    acc(0, 16'h0140, 0, K_MISS, "R7");
    check(n_wr == 0, "R8", "clean drop writes nothing", 32'(n_wr), 32'd0);
    acc(0, 16'h0180, 0, K_MISS, "R8");
    check(n_wr == 1, "R8", "dirty eviction write count", 32'(n_wr), 32'd1);
    check(op_we[op_we.size()-2] == 1'b1 && op_la[op_la.size()-2] == 0, "R8",
          "write-back before refill", 32'(op_la[op_la.size()-2]), 32'h0);
    check(op_we[op_we.size()-1] == 1'b0 && op_la[op_la.size()-1] == 16'h60, "R8",
          "refill after write-back", 32'(op_la[op_la.size()-1]), 32'h60);
    check(mem_line(0)[63:32] == 32'hDEADBEEF, "R8", "written-back word",
          mem_line(0)[63:32], 32'hDEADBEEF);

    acc(0, 16'h0101, 0, K_VICT, "R7");
    acc(0, 16'h0042, 0, K_MISS, "R7");
    acc(0, 16'h0001, 0, K_MISS, "R9");

    acc(0, 16'h0004, 0, K_MISS, "R3");
    acc(0, 16'h0044, 0, K_MISS, "R4");
    acc(1, 16'h0006, 32'h12345678, K_VICT, "R9");
    acc(0, 16'h0006, 0, K_MAIN, "R9");
    acc(0, 16'h0045, 0, K_VICT, "R5");

    acc(1, 16'h0208, 32'hA5A50F0F, K_MISS, "R9");
    acc(0, 16'h0208, 0, K_MAIN, "R9");
    check(n_wr == 1, "R8", "no extra write-backs", 32'(n_wr), 32'd1);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "R1", "watchdog expired", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule